// File: doc/BRIEF.md
# Core Event-Output and Status Register Port

This block sits between a pair of small processor cores and a shared interrupt controller. Each core owns one special register that does not store data. A core write turns the low vector field of the written word into an event pulse one clock wide. The pulses from all cores are ORed into one 32-bit event bus. Bit n of that bus drives system event 32+n of the interrupt controller.

Reading the same register returns a status word for the core. The low 30 bits hold that core's general-purpose input pins after a two-flop synchronizer. The top two bits hold the two host interrupt lines, which both cores share.

Each core has a small state machine with two states. PG_IDLE means no event is pending. PG_FIRE means an event is being driven this cycle. Three transitions exist. PG_IDLE goes to PG_FIRE on a valid write. PG_FIRE goes to PG_FIRE on a valid write in the firing cycle, which gives back-to-back pulses. PG_FIRE goes to PG_IDLE when there is no valid write.

Top module: `evt_status_port`

## Requirements
- R1: After reset, `evt_bus` is all zero and `rd_data[c][29:0]` is zero for every core.
- R2: A write on core c with bit 5 set and bits [4:0] equal to n sets exactly bit n of `evt_bus` in the cycle after the write. Bus bit n feeds controller system event 32+n.
- R3: A write whose bit 5 is clear produces no event: `evt_bus` stays zero in the following cycle.
- R4: Write bits [31:6] have no effect on which event bit fires.
- R5: Each event pulse is exactly one clock wide. With no new valid write, `evt_bus` returns to zero one cycle later.
- R6: Events from different cores in the same cycle appear ORed together on `evt_bus`. If both cores write the same number in the same cycle, a single bit is set.
- R7: `rd_data[c][29:0]` equals `gpi[c]` as it was two clock edges earlier, through a two-flop synchronizer.
- R8: `rd_data[c][30]` equals `host_irq[0]` and `rd_data[c][31]` equals `host_irq[1]`, with no delay, for every core.
- R9: Valid writes on consecutive cycles from one core give pulses on consecutive cycles. Each pulse carries its own vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NCORE | Per-core register write strobe |
| wr_data | input | NCORE x 32 | Per-core write word: [4:0] vector, [5] valid, [31:6] ignored |
| gpi | input | NCORE x 30 | Per-core general-purpose input pins, asynchronous |
| host_irq | input | 2 | Host interrupt lines 0 and 1 from the controller |
| rd_data | output | NCORE x 32 | Per-core status word: [29:0] synced pins, [30] host_irq[0], [31] host_irq[1] |
| evt_bus | output | 32 | Merged event pulses; bit n feeds system event 32+n |

## Verification
The bench sweeps all 32 vectors on both cores and puts noise in the reserved bits. A design that decoded the wrong field, or that let upper bits leak into the decode, would set a wrong bus bit. Writes with the valid bit clear must leave the bus silent. Pulses are checked to end after one cycle, which catches a design that holds the pulse high. Simultaneous writes with equal and with different vectors catch a merge that drops a core's event. Back-to-back writes catch a machine that forces a return to idle between pulses. Input-pin changes are sampled one and two cycles after they occur. A missing or extra synchronizer stage shows up as the new value arriving too early or too late. All four combinations of the host interrupt lines are checked on both cores, which catches swapped bits.

// File: rtl/evt_port_pkg.sv
package evt_port_pkg;
    localparam int DATA_W    = 32;
    localparam int VEC_W     = 5;
    localparam int VALID_BIT = VEC_W;
    localparam int EVT_W     = 1 << VEC_W;
    localparam int GPI_W     = DATA_W - 2;

    typedef enum logic [0:0] {
        PG_IDLE = 1'b0,
        PG_FIRE = 1'b1
    } pg_state_e;
endpackage

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen
    import evt_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [EVT_W-1:0]  pulse
);
    pg_state_e        state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             fire_req;

    assign fire_req = wr_en && wr_data[VALID_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE: if (fire_req) state_d = PG_FIRE;
            PG_FIRE: state_d = fire_req ? PG_FIRE : PG_IDLE;
            default: state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire_req) vec_q <= wr_data[VEC_W-1:0];
        end
    end

    always_comb begin
        pulse = '0;
        unique case (state_q)
            PG_IDLE: pulse = '0;
            PG_FIRE: pulse[vec_q] = 1'b1;
            default: pulse = '0;
        endcase
    end

    // R2: a valid write lights the selected bit next cycle
    p_fire_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_req |=> pulse[$past(wr_data[VEC_W-1:0])]);
    // R3: no valid write means no pulse next cycle
    p_no_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_req |=> (pulse == '0));
    // R5: at most one bit per core per cycle
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));
endmodule

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
            age_q  <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    // R7: output is the input from two edges earlier once the pipe is full
    p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (q_sync == $past(d_async, 2)));
endmodule

// File: rtl/evt_status_port.sv
module evt_status_port
    import evt_port_pkg::*;
#(
    parameter int NCORE = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORE-1:0]             wr_en,
    input  logic [NCORE-1:0][DATA_W-1:0] wr_data,
    input  logic [NCORE-1:0][GPI_W-1:0]  gpi,
    input  logic [1:0]                   host_irq,
    output logic [NCORE-1:0][DATA_W-1:0] rd_data,
    output logic [EVT_W-1:0]             evt_bus
);
    logic [NCORE-1:0][EVT_W-1:0] core_pulse;
    logic [NCORE-1:0][GPI_W-1:0] gpi_s;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        evt_pulse_gen u_pg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[c]),
            .wr_data (wr_data[c]),
            .pulse   (core_pulse[c])
        );
        gpi_sync #(.W(GPI_W)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (gpi[c]),
            .q_sync  (gpi_s[c])
        );
        assign rd_data[c] = {host_irq[1], host_irq[0], gpi_s[c]};
    end

    always_comb begin
        evt_bus = '0;
        for (int c = 0; c < NCORE; c++) evt_bus |= core_pulse[c];
    end

    // R6: bus carries at most one bit per core
    p_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(evt_bus) <= NCORE);
    // R5: a lit bus bit with no valid writes is cleared next cycle
    p_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_bus != '0) && ((wr_en & {NCORE{1'b1}}) == '0)) |=> (evt_bus == '0));
endmodule

// File: tb/tb_evt_status_port.sv
module tb_evt_status_port;
    localparam int NC = 2;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]        wr_en = '0;
    logic [NC-1:0][31:0]  wr_data = '0;
    logic [NC-1:0][29:0]  gpi = '0;
    logic [1:0]           host_irq = '0;
    logic [NC-1:0][31:0]  rd_data;
    logic [31:0]          evt_bus;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_status_port #(.NCORE(NC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .gpi(gpi), .host_irq(host_irq), .rd_data(rd_data), .evt_bus(evt_bus)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [31:0] junk;
        repeat (3) @(negedge clk);
        chk(evt_bus, 32'h0, "R1 evt_bus in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(evt_bus, 32'h0, "R1 evt_bus after reset");
        for (int c = 0; c < NC; c++) chk({2'b0, rd_data[c][29:0]}, 32'h0, "R1 rd_data pins");

        // R2 R4 R5: every vector, both cores, noise in reserved bits
        junk = 32'h9e37_79b9;
        for (int c = 0; c < NC; c++) begin
            for (int n = 0; n < 32; n++) begin
                junk = junk * 32'd1103515245 + 32'd12345;
                wr_en = '0; wr_en[c] = 1'b1;
                wr_data[c] = {junk[31:6], 1'b1, n[4:0]};
                @(negedge clk);
                wr_en = '0;
                chk(evt_bus, 32'h1 << n, "R2 R4 vector decode");
                @(negedge clk);
                chk(evt_bus, 32'h0, "R5 pulse one cycle");
            end
        end

        // R3: valid clear, every vector
        for (int n = 0; n < 32; n++) begin
            wr_en = 2'b11;
            wr_data[0] = {26'h3ff_ffff, 1'b0, n[4:0]};
            wr_data[1] = {26'h0, 1'b0, n[4:0]};
            @(negedge clk);
            wr_en = '0;
            chk(evt_bus, 32'h0, "R3 valid clear");
        end

        // R6: simultaneous writes
        for (int a = 0; a < 32; a += 3) begin
            for (int b = 0; b < 32; b += 5) begin
                wr_en = 2'b11;
                wr_data[0] = {26'h0, 1'b1, a[4:0]};
                wr_data[1] = {26'h155, 1'b1, b[4:0]};
                @(negedge clk);
                wr_en = '0;
                chk(evt_bus, (32'h1 << a) | (32'h1 << b), "R6 merge");
                @(negedge clk);
            end
        end

        // R9: back-to-back from one core
        wr_en = 2'b01;
        for (int n = 0; n < 8; n++) begin
            wr_data[0] = {26'h0, 1'b1, 5'(n * 7)};
            @(negedge clk);
            chk(evt_bus, 32'h1 << ((n * 7) % 32), "R9 back to back");
        end
        wr_en = '0;
        @(negedge clk);
        chk(evt_bus, 32'h0, "R5 end of burst");

        // R7: synchronizer latency
        for (int k = 0; k < 6; k++) begin
            logic [29:0] prev0, prev1, nv0, nv1;
            prev0 = rd_data[0][29:0]; prev1 = rd_data[1][29:0];
            nv0 = 30'h2aaa_aaaa ^ 30'(k * 32'h0123_4567);
            nv1 = ~nv0;
            gpi[0] = nv0; gpi[1] = nv1;
            @(negedge clk);
            chk({2'b0, rd_data[0][29:0]}, {2'b0, prev0}, "R7 not after one edge c0");
            chk({2'b0, rd_data[1][29:0]}, {2'b0, prev1}, "R7 not after one edge c1");
            @(negedge clk);
            chk({2'b0, rd_data[0][29:0]}, {2'b0, nv0}, "R7 after two edges c0");
            chk({2'b0, rd_data[1][29:0]}, {2'b0, nv1}, "R7 after two edges c1");
        end

        // R8: host interrupt bits, live
        for (int h = 0; h < 4; h++) begin
            host_irq = h[1:0];
            #1;
            for (int c = 0; c < NC; c++)
                chk({30'h0, rd_data[c][31:30]}, {30'h0, h[1:0]}, "R8 host irq bits");
        end

        done = 1;
        summary();
    end
endmodule